// File: doc/BRIEF.md
# Return Stack and Interrupt Sequencer

This block decides, every cycle, the address of the next instruction for a small single-cycle processor. It receives the raw 14-bit instruction word, the address of the instruction now executing and the current zero and carry flags. From these it works out sequential flow, absolute jumps, conditional jumps on either flag, and subroutine calls and returns. Return addresses are kept in an internal last-in-first-out store. Each entry also saves both flags, so that leaving an interrupt handler can give them back to the core.

A single interrupt request line is handled here as well. A request is accepted only when software has enabled interrupts, no interrupt is already being serviced, and the instruction now executing is not on the protected list. The accepting instruction still completes. In the following cycle the block ignores the fetched word and performs a forced call to the interrupt vector. That cycle is flagged on `irq_entry` so that the core discards the word, and `int_ack` rises in it. The acknowledge stays high until the handler executes its interrupt return. While synchronous reset is held low, the next address is forced to the reset vector.

Top module: `flow_stack_ctrl`

## Requirements
- R1: While `rst_n` is low, `pc_next` equals 0x000, and `int_ack`, `irq_entry` and `flags_restore` are 0. After reset, interrupts are disabled, the stack is empty and all entries read as zero.
- R2: Any word with bit 13 set (register loads, register operations, port reads) and any port write (bits 13:10 = 0011) gives `pc_next = pc + 1`, wrapping from 0x3FF to 0x000.
- R3: An absolute jump (bits 13:10 = 0001) gives `pc_next` = bits 9:0 and leaves the stack unchanged.
- R4: A conditional jump has bits 13:12 = 01 and the target in bits 9:0. Bits 11:10 pick the test: 00 jumps if Z=1, 01 if Z=0, 10 if C=1, 11 if C=0. When the test fails, `pc_next = pc + 1`.
- R5: A call (bits 13:10 = 0000) pushes `pc + 1` with the current flags and jumps to bits 9:0. A plain return (bits 13:8 = 001000) pops an entry, jumps to its address and keeps `flags_restore` low.
- R6: The stack holds 16 entries in last-in-first-out order. The pointer wraps modulo 16, so a 17th nested push overwrites the oldest entry and no overflow is reported.
- R7: An interrupt return (bits 13:8 = 001001) pops an entry and jumps to its address. In the same cycle it drives `flags_restore` high with the saved Z on `z_restored` and the saved C on `c_restored`, and `int_ack` falls at the next edge.
- R8: A request is accepted when `int_req` is 1, `int_ack` is 0, interrupts are enabled, and the executing word is interruptible. The word still executes. In the next cycle `irq_entry` and `int_ack` are 1, the fetched word is ignored, `pc` and both flags are pushed, and `pc_next` is 0x001.
- R9: Enable (bits 13:8 = 001011), disable (001010), interrupt return, port writes (bits 13:10 = 0011) and port reads (bits 13:10 = 1111) are never interrupted.
- R10: Enable sets the interrupt enable and disable clears it, taking effect from the next instruction.
- R11: While `int_ack` is high, no further request is accepted, whatever `int_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 14 | Instruction word now executing |
| pc | input | 10 | Address of the instruction now executing |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| int_req | input | 1 | Interrupt request |
| pc_next | output | 10 | Address of the next instruction |
| int_ack | output | 1 | Interrupt being serviced |
| irq_entry | output | 1 | Forced vector call this cycle; core discards the word |
| flags_restore | output | 1 | Load Z and C from the restored values this cycle |
| z_restored | output | 1 | Zero flag saved in the popped entry |
| c_restored | output | 1 | Carry flag saved in the popped entry |

## Verification
The assertions check on every cycle that:
- sequential words step by one and absolute jumps go to their target;
- a vector cycle goes to 0x001 with the acknowledge high, and the acknowledge rises only in a vector cycle;
- the acknowledge falls only after an interrupt return and holds until one executes;
- protected words never lead to a vector cycle;
- flags are restored only on an interrupt return.

Last-in-first-out order across 16 and 17 nested calls, the pointer wrap that loses the oldest entry, and the saved flags coming back are shown only by the bench's scenarios. The same holds for the enable and disable timing and for an interrupt taken on a call, which needs both return addresses in the right order.

// File: rtl/fsc_pkg.sv
// Shared types for the flow/stack controller.
// Assumes the 14-bit instruction format with a 2-bit major class in bits 13:12.
package fsc_pkg;
    localparam int IW = 14;

    typedef enum logic [3:0] {
        K_SEQ,
        K_CALL,
        K_GOTO,
        K_RET,
        K_RETI,
        K_DI,
        K_EI,
        K_PORT,
        K_JUMP
    } op_kind_e;

    typedef enum logic [1:0] {
        C_Z  = 2'b00,
        C_NZ = 2'b01,
        C_C  = 2'b10,
        C_NC = 2'b11
    } cond_e;
endpackage

// File: rtl/fsc_decode.sv
// Instruction classifier: maps a raw word to a flow kind, a jump test and a
// target, and says whether the word may be interrupted.
// Assumes AW <= IW-4 so the target field fits below the class bits.
module fsc_decode
    import fsc_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [IW-1:0] instr,
    output op_kind_e      kind,
    output cond_e         cond,
    output logic [AW-1:0] target,
    output logic          interruptible
);
    // Classify the word by its major and minor class fields.
    always_comb begin
        target = instr[AW-1:0];
        cond   = cond_e'(instr[IW-3:IW-4]);
        kind   = K_SEQ;
        case (instr[IW-1:IW-2])
            2'b00: begin
                case (instr[IW-3:IW-4])
                    2'b00: kind = K_CALL;
                    2'b01: kind = K_GOTO;
                    2'b10: begin
                        case (instr[IW-5:IW-6])
                            2'b00:   kind = K_RET;
                            2'b01:   kind = K_RETI;
                            2'b10:   kind = K_DI;
                            default: kind = K_EI;
                        endcase
                    end
                    default: kind = K_PORT;
                endcase
            end
            2'b01:   kind = K_JUMP;
            2'b10:   kind = K_SEQ;
            default: kind = (instr[IW-3:IW-4] == 2'b11) ? K_PORT : K_SEQ;
        endcase
    end

    // Protected words: enable, disable, interrupt return and port accesses.
    always_comb begin
        interruptible = !(kind == K_RETI || kind == K_DI ||
                          kind == K_EI   || kind == K_PORT);
    end
endmodule

// File: rtl/fsc_stack.sv
// Return-address store: a register-based LIFO with a wrapping pointer.
// Assumes DEPTH is a power of two and that push and pop never coincide.
// The top entry (one below the pointer) is read combinationally.
module fsc_stack #(
    parameter int DEPTH = 16,
    parameter int EW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [EW-1:0] push_data,
    output logic [EW-1:0] top_data
);
    localparam int SPW = $clog2(DEPTH);

    logic [SPW-1:0] sp;
    logic [SPW-1:0] sp_below;
    logic [EW-1:0]  mem [DEPTH];

    // Index of the most recently pushed entry.
    always_comb sp_below = sp - SPW'(1);

    // Expose that entry as the top of the stack.
    always_comb top_data = mem[sp_below];

    // Write on push, move the pointer on push or pop, clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= push_data;
            sp      <= sp + SPW'(1);
        end else if (pop) begin
            sp <= sp_below;
        end
    end
endmodule

// File: rtl/fsc_irq_ctrl.sv
// Interrupt sequencer: user enable bit, acceptance test, and the acknowledge
// and pending-vector registers. The vector call happens one cycle after
// acceptance. The caller gates set/clear/leave off during that vector cycle.
module fsc_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic int_req,
    input  logic interruptible,
    input  logic set_en,
    input  logic clr_en,
    input  logic leave,
    output logic int_ack,
    output logic vector_now
);
    logic en_q;
    logic accept;

    // Acceptance: request, nothing in service, enabled, word not protected.
    always_comb accept = int_req && !int_ack && en_q && interruptible && !vector_now;

    // Update the enable, the acknowledge and the pending vector call.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            int_ack    <= 1'b0;
            vector_now <= 1'b0;
        end else begin
            vector_now <= accept;
            if (set_en)      en_q <= 1'b1;
            else if (clr_en) en_q <= 1'b0;
            if (accept)      int_ack <= 1'b1;
            else if (leave)  int_ack <= 1'b0;
        end
    end
endmodule

// File: rtl/flow_stack_ctrl.sv
// Next-address unit with a return stack and single-source interrupt control.
// Assumes a single-cycle core that loads pc from pc_next each edge, discards
// the fetched word when irq_entry is high, and loads Z/C when flags_restore is
// high. Stack entries are {return address, Z, C}.
module flow_stack_ctrl
    import fsc_pkg::*;
#(
    parameter int            AW        = 10,
    parameter int            DEPTH     = 16,
    parameter logic [AW-1:0] RESET_VEC = '0,
    parameter logic [AW-1:0] IRQ_VEC   = AW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr,
    input  logic [AW-1:0] pc,
    input  logic          z_in,
    input  logic          c_in,
    input  logic          int_req,
    output logic [AW-1:0] pc_next,
    output logic          int_ack,
    output logic          irq_entry,
    output logic          flags_restore,
    output logic          z_restored,
    output logic          c_restored
);
    localparam int EW = AW + 2;

    op_kind_e      kind;
    cond_e         cond;
    logic [AW-1:0] target;
    logic          interruptible;
    logic          push, pop;
    logic [EW-1:0] push_data, top_data;
    logic [AW-1:0] pc_inc;
    logic          cond_hit;
    logic          exec;

    fsc_decode #(.AW(AW)) u_dec (
        .instr         (instr),
        .kind          (kind),
        .cond          (cond),
        .target        (target),
        .interruptible (interruptible)
    );

    fsc_stack #(.DEPTH(DEPTH), .EW(EW)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .push_data (push_data),
        .top_data  (top_data)
    );

    fsc_irq_ctrl u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .int_req       (int_req),
        .interruptible (interruptible),
        .set_en        (exec && kind == K_EI),
        .clr_en        (exec && kind == K_DI),
        .leave         (exec && kind == K_RETI),
        .int_ack       (int_ack),
        .vector_now    (irq_entry)
    );

    // The fetched word takes effect only outside the vector cycle.
    always_comb exec = !irq_entry;

    // Sequential successor address.
    always_comb pc_inc = pc + AW'(1);

    // Evaluate the conditional-jump test against the live flags.
    always_comb begin
        case (cond)
            C_Z:     cond_hit = z_in;
            C_NZ:    cond_hit = !z_in;
            C_C:     cond_hit = c_in;
            default: cond_hit = !c_in;
        endcase
    end

    // Select the next address and the stack operation.
    always_comb begin
        push      = 1'b0;
        pop       = 1'b0;
        push_data = {pc_inc, z_in, c_in};
        pc_next   = pc_inc;
        if (!rst_n) begin
            pc_next = RESET_VEC;
        end else if (irq_entry) begin
            push      = 1'b1;
            push_data = {pc, z_in, c_in};
            pc_next   = IRQ_VEC;
        end else begin
            case (kind)
                K_CALL: begin
                    push    = 1'b1;
                    pc_next = target;
                end
                K_GOTO: pc_next = target;
                K_RET, K_RETI: begin
                    pop     = 1'b1;
                    pc_next = top_data[EW-1:2];
                end
                K_JUMP: pc_next = cond_hit ? target : pc_inc;
                default: pc_next = pc_inc;
            endcase
        end
    end

    // Hand the saved flags back on an interrupt return.
    always_comb begin
        flags_restore = rst_n && exec && kind == K_RETI;
        z_restored    = top_data[1];
        c_restored    = top_data[0];
    end
endmodule

// File: rtl/fsc_checker.sv
// Cycle properties of flow_stack_ctrl, bound to every instance of it.
// Decodes the instruction word on its own from the documented encodings.
module fsc_checker #(
    parameter int            AW        = 10,
    parameter logic [AW-1:0] RESET_VEC = '0,
    parameter logic [AW-1:0] IRQ_VEC   = AW'(1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [13:0]   instr,
    input logic [AW-1:0] pc,
    input logic          int_req,
    input logic [AW-1:0] pc_next,
    input logic          int_ack,
    input logic          irq_entry,
    input logic          flags_restore
);
    logic protected_w;
    always_comb protected_w = (instr[13:8] == 6'b001001) || (instr[13:8] == 6'b001010) ||
                              (instr[13:8] == 6'b001011) || (instr[13:10] == 4'b0011) ||
                              (instr[13:10] == 4'b1111);

    // R1: reset forces the reset vector and quiet strobes.
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_vec_r1: assert (pc_next == RESET_VEC && !flags_restore)
                else $error("reset vector violated");
        end
    end

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_entry && instr[13]) |-> pc_next == AW'(pc + AW'(1)));

    p_goto_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_entry && instr[13:10] == 4'b0001) |-> pc_next == instr[AW-1:0]);

    p_vector_call_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_entry |-> (pc_next == IRQ_VEC && int_ack));

    p_ack_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_ack) |-> irq_entry);

    p_protected_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && !int_ack && !irq_entry && protected_w) |=> !irq_entry);

    p_ack_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !flags_restore) |=> int_ack);

    p_ack_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_ack) |-> $past(flags_restore));

    p_restore_only_reti_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags_restore |-> (instr[13:8] == 6'b001001 && !irq_entry));
endmodule

bind flow_stack_ctrl fsc_checker #(
    .AW        (AW),
    .RESET_VEC (RESET_VEC),
    .IRQ_VEC   (IRQ_VEC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr         (instr),
    .pc            (pc),
    .int_req       (int_req),
    .pc_next       (pc_next),
    .int_ack       (int_ack),
    .irq_entry     (irq_entry),
    .flags_restore (flags_restore)
);

// File: tb/tb_flow_stack_ctrl.sv
// Self-checking bench: a reference model built from the requirements predicts
// every output; scenarios sweep addresses, jump tests, nesting and interrupts.
module tb_flow_stack_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] instr = 14'h3000;
    logic [9:0]  pc = '0;
    logic        z_in = 1'b0, c_in = 1'b0, int_req = 1'b0;
    logic [9:0]  pc_next;
    logic        int_ack, irq_entry, flags_restore, z_restored, c_restored;

    int n_checks = 0;
    int n_err = 0;

    // Reference model state.
    logic [9:0]  m_pc = '0;
    logic [11:0] m_stk [16];
    logic [3:0]  m_sp = '0;
    logic        m_ie = 1'b0, m_ack = 1'b0, m_pend = 1'b0;

    localparam logic [13:0] W_NOP  = 14'b11_0000_0000_0000;
    localparam logic [13:0] W_RET  = 14'b00_1000_0000_0000;
    localparam logic [13:0] W_RETI = 14'b00_1001_0000_0000;
    localparam logic [13:0] W_DI   = 14'b00_1010_0000_0000;
    localparam logic [13:0] W_EI   = 14'b00_1011_0000_0000;
    localparam logic [13:0] W_PWR  = 14'b00_1100_0101_0011;
    localparam logic [13:0] W_PRD  = 14'b11_1100_0110_0100;

    always #2 clk = ~clk;

    flow_stack_ctrl dut (
        .clk (clk), .rst_n (rst_n), .instr (instr), .pc (pc),
        .z_in (z_in), .c_in (c_in), .int_req (int_req),
        .pc_next (pc_next), .int_ack (int_ack), .irq_entry (irq_entry),
        .flags_restore (flags_restore), .z_restored (z_restored),
        .c_restored (c_restored)
    );

    function automatic logic [13:0] w_call(input logic [9:0] a);
        return {4'b0000, a};
    endfunction
    function automatic logic [13:0] w_goto(input logic [9:0] a);
        return {4'b0001, a};
    endfunction
    function automatic logic [13:0] w_jump(input logic [1:0] t, input logic [9:0] a);
        return {2'b01, t, a};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One executed cycle: drive, predict, compare, advance the model.
    task automatic step(input string tag, input logic [13:0] w, input logic z,
                        input logic c, input logic req);
        logic [9:0]  e_pc;
        logic        e_rst, prot, acc;
        logic [11:0] ent;
        @(negedge clk);
        instr = w; z_in = z; c_in = c; int_req = req; pc = m_pc;
        #1;
        e_rst = 1'b0;
        ent   = '0;
        e_pc  = m_pc + 10'd1;
        prot  = (w[13:8] == 6'b001001) || (w[13:8] == 6'b001010) ||
                (w[13:8] == 6'b001011) || (w[13:10] == 4'b0011) || (w[13:10] == 4'b1111);
        acc   = req && !m_ack && m_ie && !prot && !m_pend;
        chk({tag, " int_ack"}, int_ack, m_ack);
        chk({tag, " irq_entry"}, irq_entry, m_pend);
        if (m_pend) begin
            e_pc = 10'h001;
            m_stk[m_sp] = {m_pc, z, c};
            m_sp = m_sp + 4'd1;
        end else begin
            casez (w)
                14'b0000??????????: begin
                    m_stk[m_sp] = {m_pc + 10'd1, z, c};
                    m_sp = m_sp + 4'd1;
                    e_pc = w[9:0];
                end
                14'b0001??????????: e_pc = w[9:0];
                14'b001000????????, 14'b001001????????: begin
                    m_sp = m_sp - 4'd1;
                    ent  = m_stk[m_sp];
                    e_pc = ent[11:2];
                    if (w[8]) begin
                        e_rst = 1'b1;
                        m_ack = 1'b0;
                    end
                end
                14'b001010????????: m_ie = 1'b0;
                14'b001011????????: m_ie = 1'b1;
                14'b01????????????: begin
                    case (w[11:10])
                        2'b00: if (z)  e_pc = w[9:0];
                        2'b01: if (!z) e_pc = w[9:0];
                        2'b10: if (c)  e_pc = w[9:0];
                        default: if (!c) e_pc = w[9:0];
                    endcase
                end
                default: ;
            endcase
        end
        chk({tag, " pc_next"}, pc_next, e_pc);
        chk({tag, " flags_restore"}, flags_restore, e_rst);
        if (e_rst) begin
            chk({tag, " z_restored"}, z_restored, ent[1]);
            chk({tag, " c_restored"}, c_restored, ent[0]);
        end
        if (acc) m_ack = 1'b1;
        m_pend = acc;
        m_pc   = e_pc;
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog expired before the scenarios completed");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_stk[i] = '0;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 pc_next", pc_next, 10'h000);
        chk("R1 int_ack", int_ack, 1'b0);
        chk("R1 irq_entry", irq_entry, 1'b0);
        chk("R1 flags_restore", flags_restore, 1'b0);
        rst_n = 1'b1;
        m_pc  = '0;

        // R2: full address sweep of sequential words, including the wrap
        for (int i = 0; i < 1024; i++) begin
            m_pc = 10'(i);
            case (i % 4)
                0: step("R2", 14'b10_0000_0000_0000 | 14'(i * 16), i[0], i[1], 1'b0);
                1: step("R2", W_NOP | 14'(i % 256), 1'b1, 1'b0, 1'b0);
                2: step("R2", W_PRD, 1'b0, 1'b1, 1'b0);
                default: step("R2", W_PWR, 1'b1, 1'b1, 1'b0);
            endcase
        end

        // R3: absolute jumps over a spread of targets
        for (int i = 0; i < 64; i++) step("R3", w_goto(10'(i * 16 + 3)), 1'b0, 1'b0, 1'b0);

        // R4: every test against every flag pair
        for (int t = 0; t < 4; t++)
            for (int f = 0; f < 4; f++)
                step("R4", w_jump(2'(t), 10'(100 + t * 40 + f)), f[1], f[0], 1'b0);

        // R5: 16 nested calls, then 16 returns in reverse order
        for (int i = 0; i < 16; i++) step("R5", w_call(10'(i * 37 + 5)), i[0], 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) step("R5", W_RET, 1'b0, 1'b0, 1'b0);

        // R6: 17 nested calls wrap the pointer and lose the oldest entry
        for (int i = 0; i < 17; i++) step("R6", w_call(10'(i * 53 + 9)), 1'b0, i[0], 1'b0);
        for (int i = 0; i < 17; i++) step("R6", W_RET, 1'b0, 1'b0, 1'b0);

        // R10: disabled after reset, so requests are ignored
        for (int i = 0; i < 3; i++) step("R10", W_NOP, 1'b0, 1'b0, 1'b1);
        // R9: the enable word itself is protected
        step("R9", W_EI, 1'b0, 1'b0, 1'b1);
        step("R9", W_NOP, 1'b0, 1'b0, 1'b0);
        // R8: accepted on a plain word, vector cycle saves Z=1 C=0
        step("R8", W_NOP, 1'b0, 1'b0, 1'b1);
        step("R8", W_NOP, 1'b1, 1'b0, 1'b1);
        // R11: further requests are ignored while in service
        for (int i = 0; i < 4; i++) step("R11", W_NOP, 1'b0, 1'b1, 1'b1);
        // R7: return restores Z=1 C=0 and drops the acknowledge
        step("R7", W_RETI, 1'b0, 1'b1, 1'b0);
        step("R7", W_NOP, 1'b0, 1'b1, 1'b0);

        // R9: each protected word with a request present
        step("R9", W_PWR, 1'b0, 1'b0, 1'b1);
        step("R9", W_NOP, 1'b0, 1'b0, 1'b0);
        step("R9", W_PRD, 1'b0, 1'b0, 1'b1);
        step("R9", W_NOP, 1'b0, 1'b0, 1'b0);
        step("R9", w_call(10'h2A0), 1'b1, 1'b1, 1'b0);
        step("R9", W_RETI, 1'b0, 1'b0, 1'b1);
        step("R9", W_NOP, 1'b0, 1'b0, 1'b0);

        // R8: interrupt taken on a call; both return addresses come back in order
        step("R8", w_call(10'h155), 1'b0, 1'b1, 1'b1);
        step("R8", W_NOP, 1'b0, 1'b1, 1'b0);
        step("R7", W_RETI, 1'b1, 1'b0, 1'b0);
        step("R5", W_RET, 1'b0, 1'b0, 1'b0);

        // R10: disable, then requests are ignored again
        step("R10", W_DI, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 3; i++) step("R10", W_NOP, 1'b0, 1'b0, 1'b1);

        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule